// File: doc/BRIEF.md
# Scanline IRQ Down-Counter

This block raises an interrupt after a programmed number of rendered scanlines. Software writes a reload value, requests a reload, and arms the interrupt. A pulse arrives once per scanline with that line's number and a flag saying whether rendering is on. Only lines 0 to 239 count, and only while rendering is on. On each counted line the down-counter either reloads from the stored value or steps down by one. When it steps from a nonzero value to zero and the interrupt is armed, the interrupt line goes high. It stays high until software disarms it.

Each of the four control actions can be reached through two address windows. One window is a small I/O page at 0x4101 to 0x4104. The other is the cartridge space, where an address is decoded under the mask 0xE001. Both paths act the same way. Writes to any other address are ignored.

Top module: `scanline_irq_counter`

## Requirements
- R1: A write to the reload value stores the data with bit 0 forced to 0. For example, 0x05 stores 4, and 0x01 stores 0.
- R2: The four actions decode at two windows. Reload value is at 0x4101 or `addr & 0xE001 == 0xC000`. Reload request is at 0x4102 or `== 0xC001`. Disarm is at 0x4103 or `== 0xE000`. Arm is at 0x4104 or `== 0xE001`.
- R3: A reload-request write sets a pending flag. If that write falls in the same cycle as a counted line, the flag is still set afterwards.
- R4: A disarm write clears the arm state, and irq_o is low from the next cycle on.
- R5: An arm write enables the interrupt from the next cycle on.
- R6: A line pulse counts only if line_num_i is 239 or less and render_en_i is high. Any other pulse leaves the counter unchanged.
- R7: On a counted line, the counter loads the stored reload value when it is zero or a reload is pending, and the pending flag clears. Otherwise the counter decrements by one. The reload value in effect before a same-cycle reload-value write is the one used.
- R8: irq_o rises in the cycle after a counted line that takes the counter from nonzero to zero, if the interrupt was armed before that line.
- R9: Once high, irq_o stays high until a disarm write, whatever lines follow.
- R10: After reset, irq_o is low, the interrupt is disarmed, and the counter, reload value and pending flag are zero.
- R11: A disarm write in the same cycle as a zero-crossing line leaves irq_o low. An arm write in the same cycle as a zero-crossing line does not raise irq_o for that line.
- R12: Writes to any other address (for example 0x4100, 0x4105, 0x4114, 0xA000, 0x8001, 0x6001) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU write strobe, one cycle per write |
| wr_addr_i | input | 16 | CPU write address |
| wr_data_i | input | 8 | CPU write data |
| line_pulse_i | input | 1 | One-cycle pulse per scanline |
| line_num_i | input | 9 | Number of the current scanline |
| render_en_i | input | 1 | Rendering enabled |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Two things can fall in the same cycle: a control write from the CPU, and the counted line that takes the counter to zero. The bench drives both in one cycle in three ways: a disarm write, an arm write, and a reload-request write, each landing on a counted line. It then reads irq_o on the following cycles. After the disarm, irq_o must stay low. After the arm, no interrupt may come from that crossing. After the reload request, the line count to the next interrupt shows whether the pending flag survived the line that consumed it.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;
  localparam int unsigned CMD_N      = 4;
  localparam int unsigned CMD_LATCH  = 0;
  localparam int unsigned CMD_RELOAD = 1;
  localparam int unsigned CMD_DIS    = 2;
  localparam int unsigned CMD_EN     = 3;
  typedef logic [CMD_N-1:0] cmd_t;
endpackage

// File: rtl/scan_irq_decode.sv
module scan_irq_decode
  import scan_irq_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] IO_BASE   = 16'h4100,
  parameter logic [ADDR_W-1:0] CART_MASK = 16'hE001,
  parameter logic [ADDR_W-1:0] CART_BASE = 16'hC000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output cmd_t              cmd_o
);
  // cartridge codes: bit 13 picks latch/reload vs dis/en pair, bit 0 the member
  localparam logic [ADDR_W-1:0] CART_HI = 16'h2000;

  cmd_t hit_io, hit_cart;

  for (genvar i = 0; i < CMD_N; i++) begin : g_cmd
    localparam logic [ADDR_W-1:0] IO_A   = IO_BASE + ADDR_W'(i + 1);
    localparam logic [ADDR_W-1:0] CART_A = CART_BASE
                                         | ((i >= 2) ? CART_HI : '0)
                                         | ADDR_W'(i % 2);
    assign hit_io[i]   = (addr_i == IO_A);
    assign hit_cart[i] = ((addr_i & CART_MASK) == CART_A);
  end

  assign cmd_o = wr_en_i ? (hit_io | hit_cart) : '0;

  // R2
  cmd_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_o));
  // R12
  no_cmd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |-> (cmd_o == '0));
endmodule

// File: rtl/scan_irq_count.sv
module scan_irq_count #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             latch_wr_i,
  input  logic             reload_wr_i,
  input  logic [CNT_W-1:0] data_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, latch_q;
  logic             reload_q, reload_d;

  always_comb begin
    cnt_d    = cnt_q;
    reload_d = reload_q;
    if (tick_i) begin
      if (cnt_q == '0 || reload_q) begin
        cnt_d    = latch_q;
        reload_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    if (reload_wr_i) reload_d = 1'b1;  // write outranks consumption
  end

  assign hit_o = tick_i && (cnt_q != '0) && (cnt_d == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      reload_q <= 1'b0;
      latch_q  <= '0;
    end else begin
      cnt_q    <= cnt_d;
      reload_q <= reload_d;
      if (latch_wr_i) latch_q <= {data_i[CNT_W-1:1], 1'b0};
    end
  end

  // R7
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && (cnt_q == '0 || reload_q) |=> cnt_q == $past(latch_q));
  // R7
  dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && cnt_q != '0 && !reload_q |=> cnt_q == $past(cnt_q) - 1'b1);
  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  // R3
  reload_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_wr_i |=> reload_q);
  // R1
  latch_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_wr_i |=> !latch_q[0]);
endmodule

// File: rtl/scan_irq_gate.sv
module scan_irq_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_wr_i,
  input  logic dis_wr_i,
  input  logic hit_i,
  output logic irq_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      if (dis_wr_i)     en_q <= 1'b0;
      else if (en_wr_i) en_q <= 1'b1;
      if (dis_wr_i)            irq_o <= 1'b0;
      else if (hit_i && en_q)  irq_o <= 1'b1;
    end
  end

  // R8
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(en_q) && $past(hit_i));
  // R4
  dis_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_wr_i |=> !irq_o && !en_q);
  // R9
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !dis_wr_i |=> irq_o);
  // R5
  arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr_i |=> en_q);
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
  import scan_irq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned LINE_W    = 9,
  parameter int unsigned LAST_LINE = 239
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              line_pulse_i,
  input  logic [LINE_W-1:0] line_num_i,
  input  logic              render_en_i,
  output logic              irq_o
);
  localparam logic [LINE_W-1:0] LAST_L = LINE_W'(LAST_LINE);

  cmd_t cmd;
  logic tick, hit;

  assign tick = line_pulse_i && render_en_i && (line_num_i <= LAST_L);

  scan_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i),
    .addr_i (wr_addr_i),
    .cmd_o  (cmd)
  );

  scan_irq_count #(.CNT_W(DATA_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .latch_wr_i (cmd[CMD_LATCH]),
    .reload_wr_i(cmd[CMD_RELOAD]),
    .data_i     (wr_data_i),
    .hit_o      (hit)
  );

  scan_irq_gate u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_wr_i (cmd[CMD_EN]),
    .dis_wr_i(cmd[CMD_DIS]),
    .hit_i   (hit),
    .irq_o   (irq_o)
  );

  // R6
  off_line_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_pulse_i || !render_en_i || line_num_i > LAST_L) |-> !hit);
endmodule

// File: tb/tb_scanline_irq_counter.sv
`timescale 1ns/1ps
module tb_scanline_irq_counter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [15:0] wr_addr;
  logic [7:0] wr_data;
  logic       line_pulse;
  logic [8:0] line_num;
  logic       render_en;
  logic       irq;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  scanline_irq_counter dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .line_pulse_i(line_pulse), .line_num_i(line_num),
    .render_en_i(render_en), .irq_o(irq)
  );

  task automatic chk(input logic exp, input string req);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s: irq_o actual=%b expected=%b", req, irq, exp);
    end
  endtask

  // drive at negedge, edge happens, clear and sample at next negedge
  task automatic step(input logic we, input logic [15:0] a, input logic [7:0] d,
                      input logic pl, input logic [8:0] ln, input logic ren);
    wr_en = we; wr_addr = a; wr_data = d;
    line_pulse = pl; line_num = ln; render_en = ren;
    @(negedge clk);
    wr_en = 0; line_pulse = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    step(1, a, d, 0, 0, 1);
  endtask

  task automatic line(input logic [8:0] ln);
    step(0, 0, 0, 1, ln, 1);
  endtask

  task automatic setup(input logic [7:0] val, input logic arm);
    wr(16'h4103, 0);
    wr(16'h4101, val);
    wr(16'h4102, 0);
    if (arm) wr(16'h4104, 0);
  endtask

  task automatic t_reset();
    chk(0, "R10 reset");
    wr(16'h4104, 0);
    line(0); line(1);
    chk(0, "R10 counter zero after reset");
  endtask

  task automatic t_io_window();
    setup(8'h05, 1);               // stored 4
    line(10);                      // load 4
    line(11); line(12); line(13);  // 3,2,1
    chk(0, "R1 R7 not yet zero");
    line(14);
    chk(1, "R8 zero crossing raises irq");
    line(15); line(16); line(17);
    chk(1, "R9 irq held");
    wr(16'h4103, 0);
    chk(0, "R4 disarm clears irq");
  endtask

  task automatic t_cart_window();
    wr(16'hE000, 0);
    wr(16'hDFFE, 8'h03);          // stored 2
    wr(16'hC001, 0);
    wr(16'hFFFF, 0);              // arm
    line(0); line(1);
    chk(0, "R2 cart window count");
    line(2);
    chk(1, "R2 R5 cart window irq");
    wr(16'hE000, 0);
    chk(0, "R2 cart disarm");
  endtask

  task automatic t_lines();
    setup(8'h02, 1);
    line(0);                       // load 2
    line(240); line(300); line(511);
    step(0, 0, 0, 1, 10, 0);       // rendering off
    line(1);                       // 1
    chk(0, "R6 ignored lines did not count");
    line(239);
    chk(1, "R6 line 239 counts");
    wr(16'h4103, 0);
  endtask

  task automatic t_reload_mid();
    setup(8'h06, 1);
    line(0); line(1); line(2);     // 6,5,4
    wr(16'h4101, 8'h02);
    wr(16'h4102, 0);
    line(3);                       // load 2
    line(4);                       // 1
    chk(0, "R3 reload mid count");
    line(5);
    chk(1, "R3 R7 reload took new value");
    wr(16'h4103, 0);
  endtask

  task automatic t_ignored();
    setup(8'h02, 1);
    line(0); line(1); line(2);
    chk(1, "R12 setup irq");
    wr(16'h4100, 0); wr(16'h4105, 8'hFF); wr(16'h4114, 0);
    wr(16'hA000, 0); wr(16'h8001, 0); wr(16'h6001, 0); wr(16'h4003, 0);
    chk(1, "R12 no stray disarm");
    setup(8'h02, 0);
    line(0);
    wr(16'h4100, 0); wr(16'h4105, 8'hFF); wr(16'h4114, 0);
    wr(16'hA000, 0); wr(16'h8001, 0); wr(16'h6001, 0); wr(16'h4003, 0);
    line(1); line(2);
    chk(0, "R12 no stray arm");
  endtask

  task automatic t_collide();
    setup(8'h02, 1);
    line(0); line(1);
    step(1, 16'h4103, 0, 1, 2, 1); // disarm + crossing
    chk(0, "R11 disarm beats crossing");
    wr(16'h4104, 0);
    chk(0, "R11 crossing not latched");
    setup(8'h02, 0);
    line(0); line(1);
    step(1, 16'hE001, 0, 1, 2, 1); // arm + crossing
    chk(0, "R11 arm with crossing");
    setup(8'h04, 1);
    line(0); line(1);              // 4,3
    step(1, 16'h4102, 0, 1, 2, 1); // reload req + line -> 2, flag stays
    line(3); line(4); line(5); line(6); // load 4,3,2,1
    chk(0, "R3 pending survives same-cycle line");
    line(7);
    chk(1, "R3 R11 reload after collision");
    wr(16'h4103, 0);
  endtask

  task automatic t_reset_mid();
    setup(8'h02, 1);
    line(0);
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    chk(0, "R10 reset clears irq");
    wr(16'h4101, 8'h02); wr(16'h4102, 0);
    line(0); line(1); line(2);
    chk(0, "R10 reset disarms");
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    line_pulse = 0; line_num = 0; render_en = 1;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_io_window();
    t_cart_window();
    t_lines();
    t_reload_mid();
    t_ignored();
    t_collide();
    t_reset_mid();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule